// File: doc/BRIEF.md
# Four-Operand Carry-Save Adder

This block adds four unsigned operands of a configurable width and returns their total, widened by two bits so that no overflow can occur. The operands are reduced in two rows of full adders that keep sum bits and carry bits in separate vectors. No carry travels between bit positions inside a row. A single ripple carry-propagate adder at the end merges the last sum and carry vectors into the final value.

The total is captured in an output register on the rising clock edge, so it follows the operands by one cycle. A synchronous, active-high reset clears that register. The block also carries a reference chain of three ripple adders. This chain adds the operands one after another and is used only by the embedded checks, which compare the carry-save path against it.

Top module: `csa4_adder`

## Requirements
- R1: The result `total_q` is WIDTH+2 bits wide and never overflows. With WIDTH=4 and all four operands at 15, the result is 60 (6'b111100).
- R2: The first reduction row combines operands `opa`, `opb` and `ope` bit by bit. Its sum vector plus twice its carry vector equals opa+opb+ope.
- R3: The second reduction row combines operand `opf` with the first row's sum vector and with the first row's carry vector moved up one bit position. Its weighted outputs equal opa+opb+ope+opf.
- R4: For every combination of operands, the carry-save result equals the total produced by a chain of ripple adders, which is opa+opb+ope+opf.
- R5: The result appears on `total_q` one rising clock edge after the operands are applied. It holds the total of the operands that were present at that edge.
- R6: While `rst` is high at a rising edge, `total_q` becomes 0 whatever the operands are. Reset is synchronous and active high.
- R7: When all four operands are zero, the result is zero. When only one operand is nonzero, the result equals that operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the output register |
| opa | input | WIDTH | First operand, unsigned |
| opb | input | WIDTH | Second operand, unsigned |
| ope | input | WIDTH | Third operand, unsigned |
| opf | input | WIDTH | Fourth operand, unsigned |
| total_q | output | WIDTH+2 | Registered sum of the four operands |

## Verification
The only output is due exactly one rising edge after the operands are applied. Between the operands and that edge there is only combinational logic, followed by the output register. The bench changes the operands on a falling edge and reads `total_q` on the next falling edge, so exactly one capture edge lies between stimulus and sample. The reset value is read on the falling edge that follows a rising edge at which reset was high. The test sweeps all 65,536 operand combinations for the default width, adds random and directed cases, and compares every sample with a total computed in the bench.

// File: rtl/csa4_pkg.sv
package csa4_pkg;
  // Width of a sum of four unsigned values of n bits each
  function automatic int sum_width(input int n);
    return n + 2;
  endfunction
endpackage

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic co
);
  always_comb begin
    s  = x ^ y ^ z;
    co = (x & y) | (x & z) | (y & z);
  end
endmodule

// File: rtl/csa_row.sv
module csa_row #(
  parameter int W = 4
) (
  input  logic [W-1:0] in0,
  input  logic [W-1:0] in1,
  input  logic [W-1:0] in2,
  output logic [W-1:0] sum_v,
  output logic [W-1:0] cry_v
);
  // One independent full adder per bit; no carry crosses bit positions
  for (genvar i = 0; i < W; i++) begin : g_bit
    fa_cell u_fa (
      .x (in0[i]),
      .y (in1[i]),
      .z (in2[i]),
      .s (sum_v[i]),
      .co(cry_v[i])
    );
  end
endmodule

// File: rtl/ripple_add.sv
module ripple_add #(
  parameter int W = 6
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] chain;

  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_stage
    fa_cell u_fa (
      .x (x[i]),
      .y (y[i]),
      .z (chain[i]),
      .s (sum[i]),
      .co(chain[i+1])
    );
  end

  assign cout = chain[W];
endmodule

// File: rtl/csa4_adder.sv
module csa4_adder
  import csa4_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [WIDTH-1:0]     opa,
  input  logic [WIDTH-1:0]     opb,
  input  logic [WIDTH-1:0]     ope,
  input  logic [WIDTH-1:0]     opf,
  output logic [WIDTH+1:0]     total_q
);
  localparam int RW  = sum_width(WIDTH); // result width
  localparam int MW  = WIDTH + 1;        // second row width

  // ---------------- first carry-save row: opa, opb, ope ----------------
  logic [WIDTH-1:0] r1_sum, r1_cry;

  csa_row #(.W(WIDTH)) u_row1 (
    .in0  (opa),
    .in1  (opb),
    .in2  (ope),
    .sum_v(r1_sum),
    .cry_v(r1_cry)
  );

  // R2
  row1_weight_chk: assert property (@(posedge clk) disable iff (rst)
    (RW'(r1_sum) + (RW'(r1_cry) << 1)) == (RW'(opa) + RW'(opb) + RW'(ope)));

  // ---------------- second carry-save row: opf folded in ----------------
  logic [MW-1:0] r2_in_s, r2_in_c, r2_in_f;
  logic [MW-1:0] r2_sum, r2_cry;

  assign r2_in_s = {1'b0, r1_sum};
  assign r2_in_c = {r1_cry, 1'b0};   // carry weighs one bit higher
  assign r2_in_f = {1'b0, opf};

  csa_row #(.W(MW)) u_row2 (
    .in0  (r2_in_s),
    .in1  (r2_in_c),
    .in2  (r2_in_f),
    .sum_v(r2_sum),
    .cry_v(r2_cry)
  );

  // R3
  row2_weight_chk: assert property (@(posedge clk) disable iff (rst)
    (RW'(r2_sum) + (RW'(r2_cry) << 1)) ==
    (RW'(opa) + RW'(opb) + RW'(ope) + RW'(opf)));

  // ---------------- single carry-propagate adder ----------------
  logic [RW-1:0] cpa_x, cpa_y, csa_total;
  logic          cpa_cout;

  assign cpa_x = {1'b0, r2_sum};
  assign cpa_y = {r2_cry, 1'b0};

  ripple_add #(.W(RW)) u_cpa (
    .x   (cpa_x),
    .y   (cpa_y),
    .cin (1'b0),
    .sum (csa_total),
    .cout(cpa_cout)
  );

  // ---------------- reference chain of ripple adders ----------------
  logic [RW-1:0] ref_ab, ref_abe, ref_all;
  logic          ref_c0, ref_c1, ref_c2;

  ripple_add #(.W(RW)) u_ref0 (
    .x(RW'(opa)), .y(RW'(opb)), .cin(1'b0), .sum(ref_ab), .cout(ref_c0));
  ripple_add #(.W(RW)) u_ref1 (
    .x(ref_ab), .y(RW'(ope)), .cin(1'b0), .sum(ref_abe), .cout(ref_c1));
  ripple_add #(.W(RW)) u_ref2 (
    .x(ref_abe), .y(RW'(opf)), .cin(1'b0), .sum(ref_all), .cout(ref_c2));

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    !(cpa_cout | ref_c0 | ref_c1 | ref_c2));

  // R4
  csa_vs_ripple_chk: assert property (@(posedge clk) disable iff (rst)
    csa_total == ref_all);

  // ---------------- output register ----------------
  always_ff @(posedge clk) begin
    if (rst) total_q <= '0;
    else     total_q <= csa_total;
  end

  // R5
  out_latency_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> total_q == $past(RW'(opa) + RW'(opb) + RW'(ope) + RW'(opf)));

  // R6
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> total_q == '0);

endmodule

// File: tb/csa4_adder_bench.sv
module csa4_adder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 4;
  localparam int RW = W + 2;
  localparam int WATCHDOG_CYCLES = 190000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  opa = '0, opb = '0, ope = '0, opf = '0;
  logic [RW-1:0] total_q;

  int checks = 0;
  int bad    = 0;
  bit done   = 1'b0;

  csa4_adder #(.WIDTH(W)) u_csa4_adder (
    .clk(clk), .rst(rst),
    .opa(opa), .opb(opb), .ope(ope), .opf(opf),
    .total_q(total_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [RW-1:0] exp_total(input logic [W-1:0] a, b, e, f);
    int t;
    t = int'(a) + int'(b) + int'(e) + int'(f);
    return RW'(t);
  endfunction

  task automatic check(input string req, input logic [RW-1:0] got,
                       input logic [RW-1:0] want);
    checks++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, want);
    end
  endtask

  // Drive on a falling edge, read one rising edge later on the next falling edge
  task automatic apply(input string req, input logic [W-1:0] a, b, e, f);
    @(negedge clk);
    opa = a; opb = b; ope = e; opf = f;
    @(negedge clk);
    check(req, total_q, exp_total(a, b, e, f));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // r6_ reset state
    check("R6 reset value", total_q, '0);
    rst = 1'b0;

    // R7 zero and single-operand cases
    apply("R7 all zero", 4'd0, 4'd0, 4'd0, 4'd0);
    apply("R7 only opa", 4'd9, 4'd0, 4'd0, 4'd0);
    apply("R7 only opf", 4'd0, 4'd0, 4'd0, 4'd13);
    // R1 maximum: 15*4 = 60
    apply("R1 all ones", 4'hF, 4'hF, 4'hF, 4'hF);
    check("R1 all ones is 60", total_q, 6'd60);
    // R2 first row alone, every bit generating a carry
    apply("R2 first row carries", 4'hF, 4'hF, 4'hF, 4'h0);
    apply("R2 first row mixed", 4'hA, 4'h5, 4'h3, 4'h0);
    // R3 fourth operand meeting shifted carries
    apply("R3 fourth operand fold", 4'h7, 4'h7, 4'h0, 4'h8);
    apply("R3 alternating", 4'h5, 4'hA, 4'h5, 4'hA);

    // R5 back-to-back changes: each result belongs to its own operands
    for (int k = 0; k < 8; k++)
      apply("R5 consecutive", 4'(k), 4'(15-k), 4'(k*3), 4'(k+5));

    // R6 reset mid-run with nonzero operands
    @(negedge clk);
    opa = 4'hF; opb = 4'hE; ope = 4'hD; opf = 4'hC;
    rst = 1'b1;
    @(negedge clk);
    check("R6 reset clears output", total_q, '0);
    @(negedge clk);
    check("R6 reset holds output at zero", total_q, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R6 released, total follows", total_q, exp_total(4'hF, 4'hE, 4'hD, 4'hC));

    // R4 random operands
    for (int k = 0; k < 500; k++)
      apply("R4 random", 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom));

    // R4 exhaustive sweep of all 2^16 combinations
    for (int v = 0; v < 65536; v++)
      apply("R4 exhaustive", 4'(v), 4'(v >> 4), 4'(v >> 8), 4'(v >> 12));

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < WATCHDOG_CYCLES; c++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule